// File: doc/BRIEF.md
# Priority Vectoring Interrupt Controller

This block gathers thirteen level-sensitive interrupt requests, numbered 1 to 13, and tells the processor which one to service. Each request line has an 8-bit control byte. That byte carries a 3-bit interrupt level, a 2-bit sub-priority that breaks ties inside a level, and a flag that selects automatic vector numbering. The controller samples the request lines into a pending register. A 16-bit mask register gates the pending bits, and a mask bit of 1 blocks its source.

Among the unmasked pending sources, the controller picks the one whose 5-bit key (level and sub-priority together) is largest. If two keys are equal, the source with the lower number wins. A key below 4 means level zero, and in that case nothing is presented. When a winner exists, the controller drives its level and an 8-bit vector number toward the processor. In automatic numbering the vector is 24 plus the level. Otherwise the vector comes from one of three software-written vector bytes: one for source 8 and one each for sources 12 and 13. Every other source yields vector 0x0F. Software reaches all state through a simple byte-addressed register port.

The block has no internal sequencing: the arbitration is a single combinational pass, and the outputs are registered. The acknowledge cycle and the peripherals that raise the requests lie outside it.

Top module: `prio_vec_intc`

## Requirements
- R1: Pending bit n (read at byte offset 0x3A, bit position n, other bits zero) equals request line n as sampled at the previous clock edge.
- R2: A source competes only when it is pending and its mask bit (bit n of the mask register) is 0. A masked source never affects the outputs.
- R3: The winner is the competing source with the largest key, where the key is control-byte bits 4:0 (level in bits 4:2, sub-priority in bits 1:0). On equal keys the lowest-numbered source wins.
- R4: When no source competes, or the winning key is below 4, the level output and the vector output are both 0.
- R5: The level output equals bits 4:2 of the winner's control byte.
- R6: When bit 7 of the winner's control byte is 1, the vector output equals 24 plus the level.
- R7: When bit 7 is 0, the vector comes from the watchdog vector byte (offset 0x40) for source 8, from peripheral vector byte A (offset 0x41) for source 12, and from peripheral vector byte B (offset 0x42) for source 13. Every other source gives 0x0F.
- R8: After reset, the registers hold these values: mask 0x3FFE; control bytes of sources 1 to 7 equal to 4 times the source number; source 8 at 0x1C; sources 9 to 11 at 0x80; sources 12 and 13 at 0x00; watchdog vector 0x0F; both peripheral vectors 0x00; level and vector outputs 0.
- R9: The control byte of source n is at byte offset 0x13+n and takes write-data bits 7:0. The mask is at 0x36 and takes all 16 bits. Writes to the pending offset 0x3A are ignored. Reads of unmapped offsets return 0.
- R10: The level and vector outputs are registered. They reflect a register write one clock edge after the edge that performs the write, and a request-line change two edges after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 13 | Level-sensitive request lines, bit n is source n |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| ipl_out | output | 3 | Presented interrupt level |
| vec_out | output | 8 | Presented vector number |

## Verification
The bench targets four corner cases. The first is equal keys: a design that let the higher source number win would present the wrong vector. The second is a winner whose key sits just under or exactly at the cutoff of 4: an off-by-one there would present a level-zero request or drop a level-one request. The third is a source that is pending but masked: a design that ignored the mask would let that source win. The fourth is the source-specific vector bytes, where a swapped mapping would return another source's vector. A behavioural reference model runs alongside the design on every clock, under both directed and pseudo-random request and write traffic. It also catches designs whose outputs lag one edge more or one edge less than the required timing.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam logic [7:0] CTRL_BASE = 8'h13;
    localparam logic [7:0] MASK_ADDR = 8'h36;
    localparam logic [7:0] PEND_ADDR = 8'h3A;
    localparam logic [7:0] WDV_ADDR  = 8'h40;
    localparam logic [7:0] PVA_ADDR  = 8'h41;
    localparam logic [7:0] PVB_ADDR  = 8'h42;

    localparam logic [7:0] WDV_RST   = 8'h0F;
    localparam logic [7:0] OTHER_VEC = 8'h0F;
    localparam logic [7:0] AUTO_BASE = 8'd24;

    // Key width: 3 level bits plus 2 sub-priority bits.
    localparam int KEY_W = 5;

    // Control byte reset value per source number.
    function automatic logic [7:0] ctrl_reset(input int n);
        if (n >= 1 && n <= 7)
            return 8'(4 * n);
        else if (n == 8)
            return 8'h1C;
        else if (n >= 9 && n <= 11)
            return 8'h80;
        else
            return 8'h00;
    endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int N_SRC  = 13,
    parameter int MASK_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC:1]         irq_in,
    input  logic                   bus_wr,
    input  logic [7:0]             bus_addr,
    input  logic [MASK_W-1:0]      bus_wdata,
    output logic [MASK_W-1:0]      bus_rdata,
    output logic [N_SRC:1][KEY_W-1:0] key_o,
    output logic [N_SRC:1]         auto_o,
    output logic [N_SRC:1]         pend_o,
    output logic [MASK_W-1:0]      mask_o,
    output logic [7:0]             wdv_o,
    output logic [7:0]             pva_o,
    output logic [7:0]             pvb_o
);

    localparam logic [MASK_W-1:0] MASK_RST =
        MASK_W'(((1 << (N_SRC + 1)) - 1) & ~1);

    logic [N_SRC:1][7:0]  ctrl_q;
    logic [N_SRC:1]       pend_q;
    logic [MASK_W-1:0]    mask_q;
    logic [7:0]           wdv_q, pva_q, pvb_q;
    logic                 past_ok;

    for (genvar g = 1; g <= N_SRC; g++) begin : g_ctrl
        localparam logic [7:0] ADDR_G = 8'(CTRL_BASE + 8'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[g] <= ctrl_reset(g);
            else if (bus_wr && bus_addr == ADDR_G)
                ctrl_q[g] <= bus_wdata[7:0];
        end
        assign key_o[g]  = ctrl_q[g][KEY_W-1:0];
        assign auto_o[g] = ctrl_q[g][7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= MASK_RST;
            wdv_q   <= WDV_RST;
            pva_q   <= '0;
            pvb_q   <= '0;
            past_ok <= 1'b0;
        end else begin
            pend_q  <= irq_in;
            past_ok <= 1'b1;
            if (bus_wr) begin
                unique case (bus_addr)
                    MASK_ADDR: mask_q <= bus_wdata;
                    WDV_ADDR:  wdv_q  <= bus_wdata[7:0];
                    PVA_ADDR:  pva_q  <= bus_wdata[7:0];
                    PVB_ADDR:  pvb_q  <= bus_wdata[7:0];
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            MASK_ADDR: bus_rdata = mask_q;
            PEND_ADDR: bus_rdata = MASK_W'({pend_q, 1'b0});
            WDV_ADDR:  bus_rdata = MASK_W'(wdv_q);
            PVA_ADDR:  bus_rdata = MASK_W'(pva_q);
            PVB_ADDR:  bus_rdata = MASK_W'(pvb_q);
            default: begin
                for (int i = 1; i <= N_SRC; i++) begin
                    if (bus_addr == 8'(CTRL_BASE + 8'(i)))
                        bus_rdata = MASK_W'(ctrl_q[i]);
                end
            end
        endcase
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign wdv_o  = wdv_q;
    assign pva_o  = pva_q;
    assign pvb_o  = pvb_q;

    // R1: pending register tracks the request lines one edge later
    p_pend_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> pend_q == $past(irq_in))
        else $error("pending does not follow request lines");

    // R9: pending offset is read-only
    p_pend_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_wr && bus_addr == PEND_ADDR)) |-> pend_q == $past(irq_in))
        else $error("write reached pending register");

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_SRC   = 13,
    parameter int MIN_KEY = 4,
    localparam int ID_W   = $clog2(N_SRC + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC:1][KEY_W-1:0] key_i,
    input  logic [N_SRC:1]            auto_i,
    input  logic [N_SRC:1]            pend_i,
    input  logic [N_SRC:1]            mask_i,
    output logic                      win_valid,
    output logic [ID_W-1:0]           win_id,
    output logic                      win_auto,
    output logic [2:0]                win_lvl
);

    logic [N_SRC:1]   active;
    logic [KEY_W-1:0] best_key;
    logic [ID_W-1:0]  best_id;

    assign active = pend_i & ~mask_i;

    // Strict greater-than keeps the earliest (lowest-numbered) source on ties.
    always_comb begin
        best_key = '0;
        best_id  = '0;
        for (int i = 1; i <= N_SRC; i++) begin
            if (active[i] && key_i[i] > best_key) begin
                best_key = key_i[i];
                best_id  = ID_W'(i);
            end
        end
    end

    assign win_valid = (best_id != '0) && (int'(best_key) >= MIN_KEY);
    assign win_id    = win_valid ? best_id : '0;
    assign win_lvl   = best_key[KEY_W-1:2];
    assign win_auto  = (best_id != '0) ? auto_i[best_id] : 1'b0;

    // R2: a presented winner is always unmasked and pending
    p_win_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend_i[win_id] && !mask_i[win_id]))
        else $error("winner is not an active source");

    // R4: a valid winner sits at or above the cutoff level
    p_win_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> win_lvl != 3'd0)
        else $error("level-zero winner presented");

endmodule

// File: rtl/intc_vector.sv
module intc_vector
    import intc_pkg::*;
#(
    parameter int N_SRC    = 13,
    parameter int WDV_SRC  = 8,
    parameter int PVA_SRC  = 12,
    parameter int PVB_SRC  = 13,
    localparam int ID_W    = $clog2(N_SRC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [ID_W-1:0]  win_id,
    input  logic             win_auto,
    input  logic [2:0]       win_lvl,
    input  logic [7:0]       wdv_i,
    input  logic [7:0]       pva_i,
    input  logic [7:0]       pvb_i,
    output logic [2:0]       ipl_o,
    output logic [7:0]       vec_o
);

    localparam logic [ID_W-1:0] ID_WDV = ID_W'(WDV_SRC);
    localparam logic [ID_W-1:0] ID_PVA = ID_W'(PVA_SRC);
    localparam logic [ID_W-1:0] ID_PVB = ID_W'(PVB_SRC);

    logic [2:0] ipl_d;
    logic [7:0] vec_d;
    logic       past_ok;

    always_comb begin
        ipl_d = '0;
        vec_d = '0;
        if (win_valid) begin
            ipl_d = win_lvl;
            if (win_auto) begin
                vec_d = AUTO_BASE + 8'(win_lvl);
            end else begin
                unique case (win_id)
                    ID_WDV:  vec_d = wdv_i;
                    ID_PVA:  vec_d = pva_i;
                    ID_PVB:  vec_d = pvb_i;
                    default: vec_d = OTHER_VEC;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ipl_o   <= '0;
            vec_o   <= '0;
            past_ok <= 1'b0;
        end else begin
            ipl_o   <= ipl_d;
            vec_o   <= vec_d;
            past_ok <= 1'b1;
        end
    end

    // R4: nothing presented when no winner in the previous cycle
    p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!win_valid)) |-> (ipl_o == 3'd0 && vec_o == 8'd0))
        else $error("outputs not cleared without a winner");

    // R6: automatic numbering is offset from the presented level
    p_auto_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(win_valid && win_auto)) |-> vec_o == AUTO_BASE + 8'(ipl_o))
        else $error("automatic vector mismatch");

    // R5: presented level comes from the winner one edge earlier
    p_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(win_valid)) |-> ipl_o == $past(win_lvl))
        else $error("level mismatch");

endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int N_SRC   = 13,
    parameter int MASK_W  = 16,
    parameter int MIN_KEY = 4,
    parameter int WDV_SRC = 8,
    parameter int PVA_SRC = 12,
    parameter int PVB_SRC = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC:1]    irq_in,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [MASK_W-1:0] bus_wdata,
    output logic [MASK_W-1:0] bus_rdata,
    output logic [2:0]        ipl_out,
    output logic [7:0]        vec_out
);

    localparam int ID_W = $clog2(N_SRC + 1);

    logic [N_SRC:1][KEY_W-1:0] key_w;
    logic [N_SRC:1]            auto_w;
    logic [N_SRC:1]            pend_w;
    logic [MASK_W-1:0]         mask_w;
    logic [7:0]                wdv_w, pva_w, pvb_w;
    logic                      win_valid;
    logic [ID_W-1:0]           win_id;
    logic                      win_auto;
    logic [2:0]                win_lvl;

    intc_regfile #(.N_SRC(N_SRC), .MASK_W(MASK_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .key_o     (key_w),
        .auto_o    (auto_w),
        .pend_o    (pend_w),
        .mask_o    (mask_w),
        .wdv_o     (wdv_w),
        .pva_o     (pva_w),
        .pvb_o     (pvb_w)
    );

    logic [MASK_W-1:0] mask_unused;
    assign mask_unused = mask_w;

    intc_arbiter #(.N_SRC(N_SRC), .MIN_KEY(MIN_KEY)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_i     (key_w),
        .auto_i    (auto_w),
        .pend_i    (pend_w),
        .mask_i    (mask_unused[N_SRC:1]),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_auto  (win_auto),
        .win_lvl   (win_lvl)
    );

    intc_vector #(
        .N_SRC(N_SRC), .WDV_SRC(WDV_SRC), .PVA_SRC(PVA_SRC), .PVB_SRC(PVB_SRC)
    ) u_vec (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_auto  (win_auto),
        .win_lvl   (win_lvl),
        .wdv_i     (wdv_w),
        .pva_i     (pva_w),
        .pvb_i     (pvb_w),
        .ipl_o     (ipl_out),
        .vec_o     (vec_out)
    );

    // R4: a zero level never carries a vector
    p_zero_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ipl_out == 3'd0 |-> vec_out == 8'd0)
        else $error("vector without level");

endmodule

// File: tb/prio_vec_intc_bench.sv
module prio_vec_intc_bench;

    localparam int NS = 13;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [NS:1] irq;
    logic        wr;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [2:0]  ipl;
    logic [7:0]  vec;

    always #5 clk = ~clk;

    prio_vec_intc u_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ipl_out(ipl), .vec_out(vec)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Behavioural reference state
    logic [7:0]  m_ctrl [1:NS];
    logic [15:0] m_mask;
    logic [NS:1] m_pend;
    logic [7:0]  m_wdv, m_pva, m_pvb;
    logic [2:0]  e_ipl;
    logic [7:0]  e_vec;

    function automatic logic [10:0] ref_out();
        int bk = 0;
        int bi = 0;
        logic [2:0] l;
        logic [7:0] v;
        for (int i = 1; i <= NS; i++)
            if (m_pend[i] && !m_mask[i] && int'(m_ctrl[i][4:0]) > bk) begin
                bk = int'(m_ctrl[i][4:0]);
                bi = i;
            end
        if (bk < 4) return 11'd0;
        l = m_ctrl[bi][4:2];
        if (m_ctrl[bi][7]) v = 8'(24 + int'(l));
        else if (bi == 8)  v = m_wdv;
        else if (bi == 12) v = m_pva;
        else if (bi == 13) v = m_pvb;
        else               v = 8'h0F;
        return {l, v};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 1; i <= NS; i++)
                m_ctrl[i] = (i <= 7) ? 8'(4 * i) : (i == 8) ? 8'h1C : (i <= 11) ? 8'h80 : 8'h00;
            m_mask = 16'h3FFE; m_pend = '0;
            m_wdv = 8'h0F; m_pva = 8'h00; m_pvb = 8'h00;
            e_ipl = '0; e_vec = '0;
        end else begin
            {e_ipl, e_vec} = ref_out();
            if (wr) begin
                if (addr >= 8'h14 && addr <= 8'h20) m_ctrl[int'(addr) - 'h13] = wdata[7:0];
                else if (addr == 8'h36) m_mask = wdata;
                else if (addr == 8'h40) m_wdv = wdata[7:0];
                else if (addr == 8'h41) m_pva = wdata[7:0];
                else if (addr == 8'h42) m_pvb = wdata[7:0];
            end
            m_pend = irq;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done)
            chk({ipl, vec} == {e_ipl, e_vec}, "R3 R5 R6 R7 R10 model",
                16'({ipl, vec}), 16'({e_ipl, e_vec}));
    end

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [15:0] exp, input string req);
        @(negedge clk); addr = a;
        #1 chk(rdata == exp, req, rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_irq(input logic [NS:1] v);
        @(negedge clk); irq = v;
        settle();
    endtask

    task automatic exp_out(input logic [2:0] l, input logic [7:0] v, input string req);
        chk({ipl, vec} == {l, v}, req, 16'({ipl, vec}), 16'({l, v}));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; irq = '0; wr = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        exp_out(3'd0, 8'd0, "R8 outputs after reset");
        bus_read(8'h36, 16'h3FFE, "R8 mask reset");
        bus_read(8'h14, 16'h0004, "R8 ctrl1 reset");
        bus_read(8'h1A, 16'h001C, "R8 ctrl7 reset");
        bus_read(8'h1B, 16'h001C, "R8 ctrl8 reset");
        bus_read(8'h1C, 16'h0080, "R8 ctrl9 reset");
        bus_read(8'h1F, 16'h0000, "R8 ctrl12 reset");
        bus_read(8'h40, 16'h000F, "R8 watchdog vector reset");
        bus_read(8'h41, 16'h0000, "R8 vector A reset");

        // R2 masked source, R1 pending readback
        set_irq(13'b0000000000100);
        exp_out(3'd0, 8'd0, "R2 masked source ignored");
        bus_read(8'h3A, 16'h0008, "R1 pending bit position");
        bus_write(8'h3A, 16'hFFFF);
        bus_read(8'h3A, 16'h0008, "R9 pending write ignored");
        bus_read(8'h10, 16'h0000, "R9 unmapped read");

        bus_write(8'h36, 16'h0000);
        settle();
        exp_out(3'd3, 8'h0F, "R5 R7 level 3 default vector");

        // R10 write-to-output timing
        bus_write(8'h16, 16'h0018);
        exp_out(3'd3, 8'h0F, "R10 output not yet updated");
        @(negedge clk);
        exp_out(3'd6, 8'h0F, "R10 output one edge after write");

        // R3 tie and sub-priority
        bus_write(8'h14, 16'h0098);
        set_irq(13'b0000000000101);
        exp_out(3'd6, 8'd30, "R3 tie lowest number wins, R6 autovector");
        bus_write(8'h14, 16'h0099);
        bus_write(8'h16, 16'h001B);
        settle();
        exp_out(3'd6, 8'h0F, "R3 higher sub-priority wins");
        bus_write(8'h36, 16'h0008);
        settle();
        exp_out(3'd6, 8'd30, "R2 mask removes winner");
        bus_write(8'h36, 16'h0000);

        // R4 cutoff boundary and R7 peripheral vectors
        set_irq(13'b0100000000000);
        exp_out(3'd0, 8'd0, "R4 key zero");
        bus_write(8'h1F, 16'h0003);
        settle();
        exp_out(3'd0, 8'd0, "R4 key 3 below cutoff");
        bus_write(8'h41, 16'h0055);
        bus_write(8'h1F, 16'h0004);
        settle();
        exp_out(3'd1, 8'h55, "R4 key 4 presented, R7 vector A");
        bus_write(8'h42, 16'h0066);
        bus_write(8'h20, 16'h0008);
        set_irq(13'b1100000000000);
        exp_out(3'd2, 8'h66, "R7 vector B");

        // R7 watchdog source
        set_irq(13'b0000010000000);
        exp_out(3'd7, 8'h0F, "R7 watchdog reset vector");
        bus_write(8'h40, 16'h0042);
        settle();
        exp_out(3'd7, 8'h42, "R7 watchdog programmed vector");

        // R6 autovector, R4 with level 0 autovector source
        set_irq(13'b0000100000000);
        exp_out(3'd0, 8'd0, "R4 autovector source at level 0");
        bus_write(8'h1C, 16'h0094);
        settle();
        exp_out(3'd5, 8'd29, "R6 autovector 24 plus level");

        // Pseudo-random traffic checked by the model every cycle
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            irq = lfsr[13:1];
            wr = lfsr[0] & lfsr[7];
            case (lfsr[11:9])
                3'd0: addr = 8'h36;
                3'd1: addr = 8'h40;
                3'd2: addr = 8'h41;
                3'd3: addr = 8'h42;
                default: addr = 8'(8'h14 + 8'(int'(lfsr[15:8]) % 13));
            endcase
            wdata = {lfsr[3:0], lfsr[15:4]} & (lfsr[5] ? 16'h00FF : 16'h3FFE);
        end
        @(negedge clk); wr = 1'b0;
        repeat (3) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule